// File: doc/BRIEF.md
# Receive Gain Code Controller

This block holds the gain code for a receive amplifier chain and turns it into settings for a coarse amplifier stage and a fine amplifier stage. A five-bit code spans -6 dB to +36 dB in 2 dB steps (codes 0x00 to 0x15). The code is loaded from one of two sources. The first is a register write. The second is a set of five pins, captured when a gain strobe pin rises. One bit in the written word chooses which source is live.

A wide-bandwidth mode input caps the applied gain at 30 dB (code 0x12). The stored code is kept, so the cap lifts when the mode is cleared. The read port always returns the code that is actually in force, together with the source select bit, no matter which source loaded it.

Source handling is a three-state machine:
- `ST_PIN_IDLE`: pin source, strobe low, waiting for a rising edge.
- `ST_PIN_HOLD`: pin source, strobe seen high, waiting for it to fall.
- `ST_REG`: register source, strobe ignored.

The transitions are:
- any state to `ST_REG` on a write with bit 5 set;
- any state to `ST_PIN_IDLE` on a write with bit 5 clear while the synchronised strobe is low, or to `ST_PIN_HOLD` if the strobe is high;
- `ST_PIN_IDLE` to `ST_PIN_HOLD` on a synchronised strobe high, which also captures the pins;
- `ST_PIN_HOLD` to `ST_PIN_IDLE` when the synchronised strobe is low.

Top module: `rx_gain_ctrl`

## Requirements
- R1: After reset the stored code is 0x00, the pin source is selected, `rd_data` reads 0x00, and `coarse_sel` and `fine_sel` are both 0.
- R2: A write with `wr_data[5]`=1 selects the register source. It loads `wr_data[4:0]` as the stored code at that clock edge, and `rd_data[5]` then reads 1.
- R3: A write with `wr_data[5]`=0 selects the pin source and leaves the stored code unchanged. If a strobe capture falls in the same cycle as a write, the write wins and the capture is dropped.
- R4: With the pin source selected, a rising edge on `gain_strobe` captures `gain_pins`. The strobe passes through a two-flop synchroniser, and the new code appears within three clock edges of the strobe being sampled high.
- R5: With the register source selected, strobe edges and pin values have no effect on the code.
- R6: With the pin source selected, changes on `gain_pins` while the strobe stays low, or stays high, do not change the code.
- R7: A code above 0x15 from either source is stored as 0x15.
- R8: While `wideband_en`=1, the applied code is the lesser of the stored code and 0x12. Clearing `wideband_en` restores the stored code.
- R9: `coarse_sel` index k means -6+6k dB (0..5), and `fine_sel` index j means 2j dB (0..6). The mapping from applied code c is:
  - c 0..5: k=0, j=c;
  - c 6..17: k=1+(c-6)/3, j=3+(c-6) mod 3;
  - c 18..21 with wideband clear: k=5, j=c-15;
  - c 18 with wideband set: k=4, j=6.
- R10: `rd_data[4:0]` equals the applied code, and `rd_data[5]` is 1 for the register source and 0 for the pin source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 6 | Bit 5 is the source select; bits 4:0 are the gain code |
| wideband_en | input | 1 | Wide-bandwidth mode; caps the gain at code 0x12 |
| gain_strobe | input | 1 | Asynchronous strobe; its rising edge captures the pins |
| gain_pins | input | 5 | Gain code from the pins |
| rd_data | output | 6 | {source select, applied code} |
| gain_code | output | 5 | Applied gain code |
| coarse_sel | output | 3 | Coarse stage index |
| fine_sel | output | 3 | Fine stage index |

## Verification
The properties assume that `gain_pins` hold steady from before the strobe rises until the strobe has been sampled through the synchroniser. They also assume that `wideband_en` changes only on clock boundaries. The stimulus sets the pins a full cycle before raising the strobe, holds the strobe for several cycles, and drives every input only on the falling clock edge. The properties that compare the code across a cycle are conditioned on `wideband_en` staying low, because a mode change alone moves the applied code.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
    localparam int CODE_W   = 5;
    localparam int STAGE_W  = 3;
    localparam int LOW_TOP  = 5;   // last code handled by the lowest coarse step
    localparam int MID_TOP  = 17;  // last code of the three-code coarse steps
    localparam int WB_CODE  = 18;  // applied ceiling in wide-bandwidth mode
    localparam int MAX_CODE = 21;

    typedef enum logic [1:0] {
        ST_PIN_IDLE = 2'd0,
        ST_PIN_HOLD = 2'd1,
        ST_REG      = 2'd2
    } src_state_t;

    typedef struct packed {
        logic [STAGE_W-1:0] coarse;
        logic [STAGE_W-1:0] fine;
    } stage_t;

    function automatic stage_t split_code(logic [CODE_W-1:0] c, logic wb);
        stage_t r;
        logic [CODE_W-1:0] off;
        off = c - CODE_W'(LOW_TOP + 1);
        if (c <= CODE_W'(LOW_TOP)) begin
            r.coarse = '0;
            r.fine   = STAGE_W'(c);
        end else if (c <= CODE_W'(MID_TOP)) begin
            r.coarse = STAGE_W'(CODE_W'(1) + off / CODE_W'(3));
            r.fine   = STAGE_W'(CODE_W'(3) + off % CODE_W'(3));
        end else if (wb) begin
            r.coarse = STAGE_W'(4);
            r.fine   = STAGE_W'(6);
        end else begin
            r.coarse = STAGE_W'(5);
            r.fine   = STAGE_W'(c - CODE_W'(15));
        end
        return r;
    endfunction
endpackage

// File: rtl/rgc_sync.sv
module rgc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rgc_src_fsm.sv
module rgc_src_fsm
    import rgc_pkg::*;
#(
    parameter int W   = CODE_W,
    parameter int TOP = MAX_CODE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W:0]   wr_data,
    input  logic         strobe_s,
    input  logic [W-1:0] pins,
    output logic [W-1:0] code_q,
    output logic         src_reg
);
    src_state_t state, state_nx;
    logic         load_en;
    logic [W-1:0] load_raw;
    logic [W-1:0] load_val;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PIN_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (wr_en) begin
            if (wr_data[W])    state_nx = ST_REG;
            else if (strobe_s) state_nx = ST_PIN_HOLD;
            else               state_nx = ST_PIN_IDLE;
        end else begin
            unique case (state)
                ST_PIN_IDLE: if (strobe_s)  state_nx = ST_PIN_HOLD;
                ST_PIN_HOLD: if (!strobe_s) state_nx = ST_PIN_IDLE;
                ST_REG:      state_nx = ST_REG;
                default:     state_nx = ST_PIN_IDLE;
            endcase
        end
    end

    // Outputs: load decision and source flag
    always_comb begin
        load_en  = 1'b0;
        load_raw = '0;
        src_reg  = (state == ST_REG);
        if (wr_en) begin
            load_en  = wr_data[W];
            load_raw = wr_data[W-1:0];
        end else begin
            unique case (state)
                ST_PIN_IDLE: begin
                    load_en  = strobe_s;
                    load_raw = pins;
                end
                ST_PIN_HOLD: load_en = 1'b0;
                ST_REG:      load_en = 1'b0;
                default:     load_en = 1'b0;
            endcase
        end
        load_val = (load_raw > W'(TOP)) ? W'(TOP) : load_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       code_q <= '0;
        else if (load_en) code_q <= load_val;
    end
endmodule

// File: rtl/rgc_split.sv
module rgc_split
    import rgc_pkg::*;
#(
    parameter int W   = CODE_W,
    parameter int CAP = WB_CODE
) (
    input  logic               [W-1:0] code_q,
    input  logic                       wideband_en,
    output logic               [W-1:0] applied,
    output logic         [STAGE_W-1:0] coarse,
    output logic         [STAGE_W-1:0] fine
);
    stage_t st;

    always_comb begin
        applied = (wideband_en && code_q > W'(CAP)) ? W'(CAP) : code_q;
        st      = split_code(applied, wideband_en);
        coarse  = st.coarse;
        fine    = st.fine;
    end
endmodule

// File: rtl/rx_gain_ctrl.sv
module rx_gain_ctrl
    import rgc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W:0]   wr_data,
    input  logic              wideband_en,
    input  logic              gain_strobe,
    input  logic [CODE_W-1:0] gain_pins,
    output logic [CODE_W:0]   rd_data,
    output logic [CODE_W-1:0] gain_code,
    output logic [STAGE_W-1:0] coarse_sel,
    output logic [STAGE_W-1:0] fine_sel
);
    logic              strobe_s;
    logic [CODE_W-1:0] code_q;
    logic              src_reg;

    rgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gain_strobe),
        .q     (strobe_s)
    );

    rgc_src_fsm #(.W(CODE_W), .TOP(MAX_CODE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .strobe_s (strobe_s),
        .pins     (gain_pins),
        .code_q   (code_q),
        .src_reg  (src_reg)
    );

    rgc_split #(.W(CODE_W), .CAP(WB_CODE)) u_split (
        .code_q      (code_q),
        .wideband_en (wideband_en),
        .applied     (gain_code),
        .coarse      (coarse_sel),
        .fine        (fine_sel)
    );

    assign rd_data = {src_reg, gain_code};
endmodule

// File: rtl/rx_gain_ctrl_chk.sv
module rx_gain_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [5:0] wr_data,
    input logic       wideband_en,
    input logic [5:0] rd_data,
    input logic [4:0] gain_code,
    input logic [2:0] coarse_sel,
    input logic [2:0] fine_sel
);
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) gain_code <= 5'd21); // R7
    AST_WB_CEILING: assert property (@(posedge clk) disable iff (!rst_n) wideband_en |-> gain_code <= 5'd18); // R8
    AST_STAGE_SUM: assert property (@(posedge clk) disable iff (!rst_n) (6'(coarse_sel) * 6'd3 + 6'(fine_sel)) == 6'(gain_code)); // R9
    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[5] && !wideband_en) |=> (wideband_en || (rd_data[5] && gain_code == (($past(wr_data[4:0]) > 5'd21) ? 5'd21 : $past(wr_data[4:0]))))); // R2
    AST_PIN_SEL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_data[5] && !wideband_en) |=> (wideband_en || (!rd_data[5] && gain_code == $past(gain_code)))); // R3
    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[5] && !wr_en && !wideband_en) |=> (wideband_en || gain_code == $past(gain_code))); // R5
endmodule

bind rx_gain_ctrl rx_gain_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .wideband_en (wideband_en),
    .rd_data     (rd_data),
    .gain_code   (gain_code),
    .coarse_sel  (coarse_sel),
    .fine_sel    (fine_sel)
);

// File: tb/sim_rx_gain_ctrl.sv
`timescale 1ns/1ps
module sim_rx_gain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = '0;
    logic       wideband_en = 1'b0;
    logic       gain_strobe = 1'b0;
    logic [4:0] gain_pins = '0;
    logic [5:0] rd_data;
    logic [4:0] gain_code;
    logic [2:0] coarse_sel;
    logic [2:0] fine_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] rd;
        logic [4:0] code;
        logic [2:0] k;
        logic [2:0] j;
        string      tag;
    } exp_t;
    exp_t q[$];

    // model state
    int  m_code = 0;
    bit  m_src  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_gain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wideband_en(wideband_en), .gain_strobe(gain_strobe), .gain_pins(gain_pins),
        .rd_data(rd_data), .gain_code(gain_code), .coarse_sel(coarse_sel), .fine_sel(fine_sel)
    );

    function automatic int clamp_in(int v);
        return (v > 21) ? 21 : v;
    endfunction

    task automatic push_exp(string tag);
        exp_t e;
        int a;
        int k;
        int j;
        a = (wideband_en && m_code > 18) ? 18 : m_code;
        if (a <= 5) begin k = 0; j = a; end
        else if (a <= 17) begin k = 1 + (a - 6) / 3; j = 3 + (a - 6) % 3; end
        else if (wideband_en) begin k = 4; j = 6; end
        else begin k = 5; j = a - 15; end
        e.rd = {m_src, 5'(a)};
        e.code = 5'(a);
        e.k = 3'(k);
        e.j = 3'(j);
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(logic [5:0] d, string tag);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_src = d[5];
        if (d[5]) m_code = clamp_in(int'(d[4:0]));
        push_exp(tag);
    endtask

    task automatic do_strobe(logic [4:0] p, string tag);
        @(negedge clk);
        gain_pins = p;
        @(negedge clk);
        gain_strobe = 1'b1;
        repeat (5) @(negedge clk);
        gain_strobe = 1'b0;
        repeat (4) @(negedge clk);
        if (!m_src) m_code = clamp_in(int'(p));
        push_exp(tag);
    endtask

    task automatic set_wb(logic v, string tag);
        @(negedge clk);
        wideband_en = v;
        push_exp(tag);
    endtask

    // monitor: pops expected items and compares, away from the active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rd_data !== e.rd || gain_code !== e.code ||
                    coarse_sel !== e.k || fine_sel !== e.j) begin
                    errors++;
                    $display("FAIL %s: rd=%h code=%0d k=%0d j=%0d expected rd=%h code=%0d k=%0d j=%0d",
                             e.tag, rd_data, gain_code, coarse_sel, fine_sel,
                             e.rd, e.code, e.k, e.j);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_exp("R1 reset state");
        do_strobe(5'h07, "R4 pin capture 0x07 / R9 mid split");
        // pins move with strobe low: no change
        @(negedge clk); gain_pins = 5'h0A;
        repeat (4) @(negedge clk);
        push_exp("R6 pins change with strobe low");
        do_strobe(5'h0C, "R4 pin capture 0x0C");
        // strobe held high while pins move
        @(negedge clk); gain_strobe = 1'b1;
        repeat (4) @(negedge clk);
        m_code = 12;
        @(negedge clk); gain_pins = 5'h02;
        repeat (4) @(negedge clk);
        push_exp("R6 pins change with strobe high");
        @(negedge clk); gain_strobe = 1'b0;
        repeat (4) @(negedge clk);
        do_strobe(5'h1F, "R7 pin code above range clamps");
        do_write(6'h29, "R2 register write code 9");
        do_strobe(5'h03, "R5 strobe ignored in register mode");
        do_write(6'h3F, "R7 register code above range clamps");
        set_wb(1'b1, "R8 wideband caps at 0x12");
        set_wb(1'b0, "R8 wideband cleared restores");
        do_write(6'h04, "R3 pin select keeps code / R10 source bit");
        do_strobe(5'h05, "R4 pin capture after reselect");
        for (int c = 0; c < 22; c++) begin
            do_write(6'h20 | 6'(c), "R9 split normal / R10 readback");
            set_wb(1'b1, "R9 split wideband / R8");
            set_wb(1'b0, "R9 split back to normal");
        end
        set_wb(1'b1, "R8 wideband on");
        do_write(6'h30, "R8 code below cap passes in wideband");
        do_write(6'h35, "R8 code above cap limited in wideband");
        set_wb(1'b0, "R8 wideband off");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule